// File: doc/BRIEF.md
# SCSI Controller Interrupt and Status Registers

This block holds the interrupt-cause register, the status register, the sequence-step register, the flags register, the first configuration register and the command register of a SCSI protocol controller. It drives one level-sensitive interrupt line. The selection and data-phase logic of the controller sit outside this block. They report to it only through single-cycle strobes: a command finished, with or without function-complete; the target disconnected; selection failed; phase, terminal-count and error updates; and loads of the sequence step and the flags.

Software reaches the block through a simple register port with one-cycle write and read strobes. Read data is registered and appears in the cycle after the read strobe. Reading the interrupt register is destructive. It returns the pending causes, zeroes them, lowers the interrupt line and strips the status register down to the phase and terminal-count bits. Writing the command register decodes four housekeeping commands: chip reset, SCSI bus reset, disconnect and interrupt test. Bit 7 of the command byte selects DMA mode.

Top module: `scsi_irq_status`

## Requirements
- R1: After reset the interrupt, status, sequence-step and flags registers read 0x00, configuration reads 0x07, and `irq_o` and `dma_mode_o` are low. Register addresses: interrupt 0, status 1, sequence step 2, flags 3, command 4, configuration 5.
- R2: Interrupt-cause bits are sticky and accumulate by OR until the interrupt register is read. Cause bits: bit 0 bus service, bit 1 function complete, bit 2 disconnect, bit 3 bus reset. `irq_o` is high in the cycle after any cause is set.
- R3: A cause raised while `irq_o` is already high leaves `irq_o` high. The line falls only on an interrupt-register read or a chip reset.
- R4: A read of address 0 returns the causes and clears them. `irq_o` is low in the cycle after the read unless a new cause arrives in the same cycle.
- R5: Status layout: bits 2:0 phase, bit 4 terminal count, bit 5 parity error, bit 6 gross error, bit 7 interrupt pending. A read of the interrupt register keeps bits 2:0 and 4 and clears bits 5 and 6.
- R6: A cause strobe in the same cycle as a clearing read survives. The read returns the old value, the new cause is held afterwards, and `irq_o` stays high.
- R7: Command opcode 0x01 (chip reset) returns every register to its R1 value, clears DMA mode, lowers `irq_o`, and pulses `chip_reset_o` high for exactly one cycle.
- R8: Command opcode 0x02 (bus reset) sets the bus-reset cause and raises the interrupt only when configuration bit 6 is 0. When that bit is 1 the command sets no cause and leaves `irq_o` low.
- R9: Command opcode 0x05 (disconnect) sets the disconnect cause, raises the interrupt, and zeroes the sequence-step and flags registers.
- R10: A selection-failure strobe zeroes the status register, replaces the causes with the disconnect cause alone, and raises the interrupt.
- R11: A done strobe sets bus service. When the function-complete qualifier is high in the same cycle, it also sets function complete.
- R12: Command opcode 0x06 (interrupt test) zeroes the cause register and raises the interrupt.
- R13: Any command write loads DMA mode from bit 7 of the written byte. The opcode is bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data, valid the cycle after `reg_rd` |
| ev_done | input | 1 | Command-end strobe (bus service) |
| ev_done_fc | input | 1 | Qualifier on `ev_done`: also set function complete |
| ev_disc | input | 1 | Target-disconnect strobe |
| ev_sel_fail | input | 1 | Selection-failure strobe |
| phase_ld | input | 1 | Load the bus phase |
| phase_val | input | PHASE_W | Bus phase value |
| tc_set | input | 1 | Terminal count reached |
| tc_clr | input | 1 | Terminal count cleared |
| par_err | input | 1 | Parity-error strobe |
| gross_err | input | 1 | Gross-error strobe |
| seq_ld | input | 1 | Load the sequence step |
| seq_val | input | SEQ_W | Sequence-step value |
| flags_ld | input | 1 | Load the flags register |
| flags_val | input | DATA_W | Flags value |
| irq_o | output | 1 | Level interrupt request |
| dma_mode_o | output | 1 | DMA mode from the last command |
| chip_reset_o | output | 1 | One-cycle pulse after a chip-reset command |

## Verification
The hardest case is a cause strobe that lands in the same cycle as the destructive read. A design that lets the clear win would drop that event and lower the line while work is still pending. The status masking is checked with the error bits set and the phase and terminal-count bits non-zero. A design that cleared all of status, or none of it, shows up on the next status read. The bus-reset command is issued with the report-disable bit in both states, since an ungated decode would raise a spurious interrupt. Selection failure is issued with older causes pending. A design that ORs in the disconnect cause instead of replacing the register returns extra bits.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int PHASE_W   = 3;
  localparam int SEQ_W     = 3;
  localparam int NUM_CAUSE = 4;

  localparam logic [2:0] A_INTR  = 3'd0;
  localparam logic [2:0] A_STAT  = 3'd1;
  localparam logic [2:0] A_SEQ   = 3'd2;
  localparam logic [2:0] A_FLAGS = 3'd3;
  localparam logic [2:0] A_CMD   = 3'd4;
  localparam logic [2:0] A_CFG   = 3'd5;

  localparam int CB_BS  = 0;
  localparam int CB_FC  = 1;
  localparam int CB_DC  = 2;
  localparam int CB_RST = 3;

  localparam int ST_TC    = 4;
  localparam int ST_PAR   = 5;
  localparam int ST_GROSS = 6;
  localparam int ST_IRQ   = 7;

  localparam logic [6:0] OP_CHIP_RST = 7'h01;
  localparam logic [6:0] OP_BUS_RST  = 7'h02;
  localparam logic [6:0] OP_DISC     = 7'h05;
  localparam logic [6:0] OP_INT_TEST = 7'h06;

  localparam logic [7:0] CFG_RST_VAL  = 8'h07;
  localparam int         CFG_NORPT_BIT = 6;

  typedef struct packed {
    logic chip_rst;
    logic bus_rst_irq;
    logic disc;
    logic int_test;
  } cmd_act_t;
endpackage

// File: rtl/scsi_irq_cmd_dec.sv
module scsi_irq_cmd_dec
  import scsi_irq_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic [DW-1:0] cmd_data,
  input  logic          cfg_noreport,
  output cmd_act_t      act,
  output logic [DW-1:0] cmd_q,
  output logic          dma_mode_q,
  output logic          chip_rst_pulse_q
);
  localparam int DMA_BIT = DW - 1;
  localparam int OP_W    = DW - 1;

  logic [OP_W-1:0] opcode;
  assign opcode = cmd_data[OP_W-1:0];

  always_comb begin
    act = '0;
    if (cmd_wr) begin
      if (opcode == OP_W'(OP_CHIP_RST)) act.chip_rst = 1'b1;
      if (opcode == OP_W'(OP_BUS_RST))  act.bus_rst_irq = !cfg_noreport;
      if (opcode == OP_W'(OP_DISC))     act.disc = 1'b1;
      if (opcode == OP_W'(OP_INT_TEST)) act.int_test = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || act.chip_rst) begin
      cmd_q      <= '0;
      dma_mode_q <= 1'b0;
    end else if (cmd_wr) begin
      cmd_q      <= cmd_data;
      dma_mode_q <= cmd_data[DMA_BIT];
    end
    chip_rst_pulse_q <= !rst && act.chip_rst;
  end
endmodule

// File: rtl/scsi_irq_cause_reg.sv
module scsi_irq_cause_reg
  import scsi_irq_pkg::*;
#(
  parameter int NC     = NUM_CAUSE,
  parameter int DC_IDX = CB_DC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_rst,
  input  logic          sel_fail,
  input  logic          int_test,
  input  logic          rd_clr,
  input  logic [NC-1:0] set_mask,
  output logic [NC-1:0] cause_q,
  output logic          irq_q
);
  logic          raise;
  logic [NC-1:0] cause_d;

  always_comb begin
    raise = (|set_mask) | sel_fail | int_test;
    if (sel_fail) begin
      cause_d = '0;
      cause_d[DC_IDX] = 1'b1;
    end else if (int_test) begin
      cause_d = set_mask;
    end else begin
      cause_d = (rd_clr ? '0 : cause_q) | set_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || chip_rst) begin
      cause_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      if (raise)       irq_q <= 1'b1;
      else if (rd_clr) irq_q <= 1'b0;
    end
  end

  // R2
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((|set_mask) && !chip_rst) |=> irq_q);

  // R3
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !rd_clr && !chip_rst) |=> irq_q);

  // R4
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !(|set_mask) && !sel_fail && !int_test && !chip_rst) |=> !irq_q);

  // R6
  keep_new_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !sel_fail && !int_test && !chip_rst)
    |=> ((cause_q & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/scsi_irq_stat_reg.sv
module scsi_irq_stat_reg
  import scsi_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PHASE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_rst,
  input  logic          sel_fail,
  input  logic          rd_clr,
  input  logic          phase_ld,
  input  logic [PW-1:0] phase_val,
  input  logic          tc_set,
  input  logic          tc_clr,
  input  logic          par_set,
  input  logic          gross_set,
  output logic [DW-1:0] stat_o
);
  logic [PW-1:0] phase_q, phase_d;
  logic tc_q, tc_d, par_q, par_d, gross_q, gross_d;

  always_comb begin
    phase_d = phase_q;
    tc_d    = tc_q;
    par_d   = par_q;
    gross_d = gross_q;
    if (sel_fail) begin
      phase_d = '0;
      tc_d    = 1'b0;
      par_d   = 1'b0;
      gross_d = 1'b0;
    end else if (rd_clr) begin
      par_d   = 1'b0;
      gross_d = 1'b0;
    end
    if (phase_ld) phase_d = phase_val;
    if (tc_set)      tc_d = 1'b1;
    else if (tc_clr) tc_d = 1'b0;
    if (par_set)   par_d = 1'b1;
    if (gross_set) gross_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || chip_rst) begin
      phase_q <= '0;
      tc_q    <= 1'b0;
      par_q   <= 1'b0;
      gross_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tc_q    <= tc_d;
      par_q   <= par_d;
      gross_q <= gross_d;
    end
  end

  always_comb begin
    stat_o = '0;
    stat_o[PW-1:0]  = phase_q;
    stat_o[ST_TC]   = tc_q;
    stat_o[ST_PAR]  = par_q;
    stat_o[ST_GROSS] = gross_q;
  end

  // R5
  rd_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !chip_rst && !sel_fail && !phase_ld && !tc_set && !tc_clr
     && !par_set && !gross_set)
    |=> (!stat_o[ST_PAR] && !stat_o[ST_GROSS]
         && stat_o[PW-1:0] == $past(stat_o[PW-1:0])
         && stat_o[ST_TC] == $past(stat_o[ST_TC])));

  // R10
  sel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_fail && !phase_ld && !tc_set && !par_set && !gross_set) |=> (stat_o == '0));
endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
  import scsi_irq_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W,
  parameter int PW  = PHASE_W,
  parameter int SW  = SEQ_W,
  parameter int NC  = NUM_CAUSE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_done,
  input  logic          ev_done_fc,
  input  logic          ev_disc,
  input  logic          ev_sel_fail,
  input  logic          phase_ld,
  input  logic [PW-1:0] phase_val,
  input  logic          tc_set,
  input  logic          tc_clr,
  input  logic          par_err,
  input  logic          gross_err,
  input  logic          seq_ld,
  input  logic [SW-1:0] seq_val,
  input  logic          flags_ld,
  input  logic [DW-1:0] flags_val,
  output logic          irq_o,
  output logic          dma_mode_o,
  output logic          chip_reset_o
);
  localparam logic [DW-1:0] CFG_INIT = DW'(CFG_RST_VAL);

  cmd_act_t      act;
  logic [DW-1:0] cmd_q, cfg_q, flags_q, stat_w;
  logic [SW-1:0] seq_q;
  logic [NC-1:0] cause_q, set_mask;
  logic          rd_clr, cmd_wr;

  assign cmd_wr = reg_wr && (reg_addr == AW'(A_CMD));
  assign rd_clr = reg_rd && (reg_addr == AW'(A_INTR));

  scsi_irq_cmd_dec #(.DW(DW)) u_dec (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(reg_wdata),
    .cfg_noreport(cfg_q[CFG_NORPT_BIT]), .act(act), .cmd_q(cmd_q),
    .dma_mode_q(dma_mode_o), .chip_rst_pulse_q(chip_reset_o)
  );

  always_comb begin
    set_mask = '0;
    set_mask[CB_BS]  = ev_done;
    set_mask[CB_FC]  = ev_done && ev_done_fc;
    set_mask[CB_DC]  = ev_disc || act.disc;
    set_mask[CB_RST] = act.bus_rst_irq;
  end

  scsi_irq_cause_reg #(.NC(NC), .DC_IDX(CB_DC)) u_cause (
    .clk(clk), .rst(rst), .chip_rst(act.chip_rst), .sel_fail(ev_sel_fail),
    .int_test(act.int_test), .rd_clr(rd_clr), .set_mask(set_mask),
    .cause_q(cause_q), .irq_q(irq_o)
  );

  scsi_irq_stat_reg #(.DW(DW), .PW(PW)) u_stat (
    .clk(clk), .rst(rst), .chip_rst(act.chip_rst), .sel_fail(ev_sel_fail),
    .rd_clr(rd_clr), .phase_ld(phase_ld), .phase_val(phase_val),
    .tc_set(tc_set), .tc_clr(tc_clr), .par_set(par_err),
    .gross_set(gross_err), .stat_o(stat_w)
  );

  always_ff @(posedge clk) begin
    if (rst || act.chip_rst) begin
      seq_q   <= '0;
      flags_q <= '0;
      cfg_q   <= CFG_INIT;
    end else begin
      if (act.disc)    seq_q <= '0;
      else if (seq_ld) seq_q <= seq_val;
      if (act.disc)      flags_q <= '0;
      else if (flags_ld) flags_q <= flags_val;
      if (reg_wr && reg_addr == AW'(A_CFG)) cfg_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        AW'(A_INTR):  reg_rdata <= DW'(cause_q);
        AW'(A_STAT):  reg_rdata <= stat_w | (DW'(irq_o) << ST_IRQ);
        AW'(A_SEQ):   reg_rdata <= DW'(seq_q);
        AW'(A_FLAGS): reg_rdata <= flags_q;
        AW'(A_CMD):   reg_rdata <= cmd_q;
        AW'(A_CFG):   reg_rdata <= cfg_q;
        default:      reg_rdata <= '0;
      endcase
    end
  end

  // R7
  chip_rst_chk: assert property (@(posedge clk) disable iff (rst)
    act.chip_rst |=> (!irq_o && !dma_mode_o && chip_reset_o && cfg_q == CFG_INIT));

  // R9
  disc_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    act.disc |=> (irq_o && seq_q == '0 && flags_q == '0 && cause_q[CB_DC]));

  // R10
  sel_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_sel_fail && !act.chip_rst) |=> (irq_o && cause_q == NC'(1 << CB_DC)));
endmodule

// File: tb/scsi_irq_status_bench.sv
module scsi_irq_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic ev_done = 0, ev_done_fc = 0, ev_disc = 0, ev_sel_fail = 0;
  logic phase_ld = 0, tc_set = 0, tc_clr = 0, par_err = 0, gross_err = 0;
  logic [2:0] phase_val = '0;
  logic seq_ld = 0, flags_ld = 0;
  logic [2:0] seq_val = '0;
  logic [7:0] flags_val = '0;
  logic irq_o, dma_mode_o, chip_reset_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_irq_status u_scsi_irq_status (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_done(ev_done),
    .ev_done_fc(ev_done_fc), .ev_disc(ev_disc), .ev_sel_fail(ev_sel_fail),
    .phase_ld(phase_ld), .phase_val(phase_val), .tc_set(tc_set), .tc_clr(tc_clr),
    .par_err(par_err), .gross_err(gross_err), .seq_ld(seq_ld), .seq_val(seq_val),
    .flags_ld(flags_ld), .flags_val(flags_val), .irq_o(irq_o),
    .dma_mode_o(dma_mode_o), .chip_reset_o(chip_reset_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic done_pulse(logic fc);
    @(negedge clk);
    ev_done = 1; ev_done_fc = fc;
    @(negedge clk);
    ev_done = 0; ev_done_fc = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 irq", 8'(irq_o), 8'h00);
    check("R1 dma", 8'(dma_mode_o), 8'h00);
    rd(3'd0, v); check("R1 intr", v, 8'h00);
    rd(3'd1, v); check("R1 stat", v, 8'h00);
    rd(3'd2, v); check("R1 seq", v, 8'h00);
    rd(3'd3, v); check("R1 flags", v, 8'h00);
    rd(3'd5, v); check("R1 cfg", v, 8'h07);
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    done_pulse(0);
    check("R2 irq up", 8'(irq_o), 8'h01);
    @(negedge clk); ev_disc = 1; @(negedge clk); ev_disc = 0;
    rd(3'd0, v); check("R2 or causes", v, 8'h05);
    check("R4 irq low after read", 8'(irq_o), 8'h00);
    rd(3'd0, v); check("R4 cleared", v, 8'h00);
  endtask

  task automatic t_reraise();
    logic [7:0] v;
    done_pulse(0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ev_done = 1;
      @(negedge clk); ev_done = 0;
      check("R3 irq held", 8'(irq_o), 8'h01);
    end
    rd(3'd0, v); check("R3 cause", v, 8'h01);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    done_pulse(0);
    @(negedge clk);
    reg_rd = 1; reg_addr = 3'd0; ev_disc = 1;
    @(negedge clk);
    reg_rd = 0; ev_disc = 0;
    check("R6 old value", reg_rdata, 8'h01);
    check("R6 irq stays", 8'(irq_o), 8'h01);
    rd(3'd0, v); check("R6 new cause kept", v, 8'h04);
  endtask

  task automatic t_status_mask();
    logic [7:0] v;
    @(negedge clk);
    phase_ld = 1; phase_val = 3'd5; tc_set = 1; par_err = 1; gross_err = 1;
    @(negedge clk);
    phase_ld = 0; tc_set = 0; par_err = 0; gross_err = 0;
    rd(3'd1, v); check("R5 stat full", v, 8'h75);
    rd(3'd0, v);
    rd(3'd1, v); check("R5 stat masked", v, 8'h15);
    @(negedge clk); tc_clr = 1; phase_ld = 1; phase_val = 3'd0;
    @(negedge clk); tc_clr = 0; phase_ld = 0;
  endtask

  task automatic t_done_fc();
    logic [7:0] v;
    done_pulse(1);
    rd(3'd0, v); check("R11 bs+fc", v, 8'h03);
    done_pulse(0);
    rd(3'd0, v); check("R11 bs only", v, 8'h01);
  endtask

  task automatic t_sel_fail();
    logic [7:0] v;
    done_pulse(1);
    @(negedge clk); phase_ld = 1; phase_val = 3'd3; tc_set = 1;
    @(negedge clk); phase_ld = 0; tc_set = 0;
    @(negedge clk); ev_sel_fail = 1;
    @(negedge clk); ev_sel_fail = 0;
    check("R10 irq", 8'(irq_o), 8'h01);
    rd(3'd1, v); check("R10 stat cleared", v, 8'h80);
    rd(3'd0, v); check("R10 dc alone", v, 8'h04);
  endtask

  task automatic t_disc_cmd();
    logic [7:0] v;
    @(negedge clk); seq_ld = 1; seq_val = 3'd4; flags_ld = 1; flags_val = 8'h5A;
    @(negedge clk); seq_ld = 0; flags_ld = 0;
    rd(3'd3, v); check("R9 flags loaded", v, 8'h5A);
    wr(3'd4, 8'h05);
    check("R9 irq", 8'(irq_o), 8'h01);
    rd(3'd2, v); check("R9 seq zero", v, 8'h00);
    rd(3'd3, v); check("R9 flags zero", v, 8'h00);
    rd(3'd0, v); check("R9 dc cause", v, 8'h04);
  endtask

  task automatic t_bus_rst();
    logic [7:0] v;
    wr(3'd5, 8'h07);
    wr(3'd4, 8'h02);
    check("R8 irq reported", 8'(irq_o), 8'h01);
    rd(3'd0, v); check("R8 rst cause", v, 8'h08);
    wr(3'd5, 8'h47);
    wr(3'd4, 8'h02);
    check("R8 irq suppressed", 8'(irq_o), 8'h00);
    rd(3'd0, v); check("R8 no cause", v, 8'h00);
  endtask

  task automatic t_int_test();
    logic [7:0] v;
    done_pulse(0);
    wr(3'd4, 8'h06);
    check("R12 irq", 8'(irq_o), 8'h01);
    rd(3'd0, v); check("R12 causes zero", v, 8'h00);
    check("R12 irq low after read", 8'(irq_o), 8'h00);
  endtask

  task automatic t_dma();
    wr(3'd4, 8'h80);
    check("R13 dma on", 8'(dma_mode_o), 8'h01);
    wr(3'd4, 8'h00);
    check("R13 dma off", 8'(dma_mode_o), 8'h00);
  endtask

  task automatic t_chip_rst();
    logic [7:0] v;
    wr(3'd5, 8'h40);
    @(negedge clk); seq_ld = 1; seq_val = 3'd2; par_err = 1;
    @(negedge clk); seq_ld = 0; par_err = 0;
    done_pulse(0);
    wr(3'd4, 8'h80);
    @(negedge clk); reg_wr = 1; reg_addr = 3'd4; reg_wdata = 8'h81;
    @(negedge clk); reg_wr = 0;
    check("R7 pulse high", 8'(chip_reset_o), 8'h01);
    check("R7 irq low", 8'(irq_o), 8'h00);
    check("R7 dma low", 8'(dma_mode_o), 8'h00);
    @(negedge clk);
    check("R7 pulse one cycle", 8'(chip_reset_o), 8'h00);
    rd(3'd5, v); check("R7 cfg", v, 8'h07);
    rd(3'd2, v); check("R7 seq", v, 8'h00);
    rd(3'd1, v); check("R7 stat", v, 8'h00);
    rd(3'd0, v); check("R7 intr", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_sticky();
    t_reraise();
    t_same_cycle();
    t_status_mask();
    t_done_fc();
    t_sel_fail();
    t_disc_cmd();
    t_bus_rst();
    t_int_test();
    t_dma();
    t_chip_rst();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule